// File: doc/BRIEF.md
# External Interrupt Request Controller

This block gathers external interrupt inputs and turns them into latched, maskable request flags for a CPU. It has eight general request lines. Each line has its own 2-bit sense select, enable bit and status flag, and each drives its own request output, so that every line can have its own vector. Detection sets the status flag. Software clears it through a write-one-to-clear strobe. A request leaves the block only when the flag and the enable bit are both 1.

A non-maskable input has its own latched flag. It is forwarded with no enable gating, and one configuration bit picks the edge it reacts to. Sixteen keyed inputs and eight wake inputs are active-low and are merged onto general lines 7 and 6. A low-power standby wake output is raised only by the sources that are allowed to end standby. Every pin passes through a two-flop synchronizer. The block does not depend on any direction setting of the pins.

Top module: `extirq_ctrl`

## Requirements
- R1: A pin change driven before rising edge k sets the matching flag at edge k+2 (two synchronizer stages plus the flag register) and not earlier.
- R2: The sense field of line n is sense_wdata_i[2n+1:2n], written when sense_we_i is 1. Code 00 sets the flag while the synchronized pin is low, 01 on a falling edge, 10 on a rising edge and 11 on either edge. A transition of a kind that is not selected leaves the flag unchanged.
- R3: irq_req_o[n] is irq_flag_o[n] AND enable bit n. The enables are written from en_wdata_i when en_we_i is 1, and a new enable value takes effect on the request output in the cycle after the write.
- R4: A 1 on flag_clr_i[n] clears flag n at the next edge. In low-level mode a clear has no effect while the pin stays low, because the flag is set again on every cycle.
- R5: When a set event and a clear of the same flag fall in the same cycle, the flag ends at 1.
- R6: The non-maskable flag nmi_req_o is set by a falling edge when the edge select bit is 0, or by a rising edge when it is 1. The edge select bit is written from nmi_cfg_wdata_i when nmi_cfg_we_i is 1. The flag is cleared by nmi_clr_i and has no enable.
- R7: Line 7 detects on the AND of pin 7, keyed inputs 15..8 and wake inputs 7..0. Line 6 detects on the AND of pin 6 and keyed inputs 7..0. A low on any of these shared inputs therefore acts as a low on that line.
- R8: stby_wake_o is 1 exactly when nmi_req_o is 1 or any of irq_req_o bits 7, 6, 2, 1, 0 is 1. Requests 5, 4 and 3 never assert it.
- R9: Reset (rst_ni low) clears all flags, enables, sense fields (low-level mode) and the edge select bit. The synchronizers reset to 1, which is the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| irq_pin_i | input | 8 | General request pins, asynchronous |
| key_i | input | 16 | Keyed inputs, active low, asynchronous |
| wake_i | input | 8 | Wake inputs, active low, asynchronous |
| nmi_pin_i | input | 1 | Non-maskable input, asynchronous |
| sense_we_i | input | 1 | Write strobe for the sense fields |
| sense_wdata_i | input | 16 | Sense fields, two bits per line |
| en_we_i | input | 1 | Write strobe for the enable bits |
| en_wdata_i | input | 8 | Enable bits |
| flag_clr_i | input | 8 | Write-one-to-clear strobes for the flags |
| nmi_cfg_we_i | input | 1 | Write strobe for the non-maskable edge select |
| nmi_cfg_wdata_i | input | 1 | Edge select: 0 falling, 1 rising |
| nmi_clr_i | input | 1 | Clear of the non-maskable flag |
| irq_flag_o | output | 8 | Status flags |
| irq_req_o | output | 8 | Gated request per line |
| nmi_req_o | output | 1 | Non-maskable request flag |
| stby_wake_o | output | 1 | Standby wake-up request |

## Verification
A pin change driven before a rising edge reaches its flag and request at the third edge after it. Each scenario drives its pins on a falling edge and checks at the falling edge after the second rising edge that nothing has happened yet. It then checks again one edge later for the set flag. Enable writes, clears and edge-select writes take effect one edge after their strobe, so those results are sampled at the next falling edge. The set-versus-clear case puts the clear strobe in exactly the third-edge cycle.

// File: rtl/extirq_pkg.sv
// Shared types for the external interrupt controller.
// Assumes the inputs handed to sense_hit are already synchronized.
package extirq_pkg;

    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_FALL = 2'b01,
        SNS_RISE = 2'b10,
        SNS_BOTH = 2'b11
    } sense_e;

    // Decide whether a line's current and previous samples form a set event.
    function automatic logic sense_hit(input sense_e mode, input logic cur, input logic prev);
        logic hit;
        case (mode)
            SNS_LOW:  hit = !cur;
            SNS_FALL: hit = prev && !cur;
            SNS_RISE: hit = !prev && cur;
            default:  hit = prev != cur;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/extirq_sync.sv
// Two-flop synchronizer followed by a one-cycle-delayed copy for edge detection.
// Assumes: the inputs are asynchronous; idle level is RST_VAL.
module extirq_sync #(
    parameter int   W       = 8,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] prev_q;

    // Shift the pins through two synchronizing stages and one history stage.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            meta_q <= {W{RST_VAL}};
            cur_q  <= {W{RST_VAL}};
            prev_q <= {W{RST_VAL}};
        end else begin
            meta_q <= async_i;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur_o  = cur_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/extirq_chan.sv
// One general request line: sense decode, set/clear status flag, enable gate.
// Assumes cur_i/prev_i are synchronized samples one cycle apart.
// A set event outranks a clear in the same cycle.
module extirq_chan
    import extirq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       cur_i,
    input  logic       prev_i,
    input  logic [1:0] sense_i,
    input  logic       clr_i,
    input  logic       en_i,
    output logic       set_o,
    output logic       flag_o,
    output logic       req_o
);
    logic flag_q;

    // Decode the selected sense mode into a set event.
    always_comb begin
        set_o = sense_hit(sense_e'(sense_i), cur_i, prev_i);
    end

    // Status flag: set has priority over the software clear.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            flag_q <= 1'b0;
        end else if (set_o) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign req_o  = flag_q & en_i;
endmodule

// File: rtl/extirq_nmi.sv
// Non-maskable input: edge select register and latched request flag.
// Assumes cur_i/prev_i are synchronized samples one cycle apart.
module extirq_nmi (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cur_i,
    input  logic prev_i,
    input  logic cfg_we_i,
    input  logic cfg_wdata_i,
    input  logic clr_i,
    output logic req_o
);
    logic rise_sel_q;
    logic hit;
    logic flag_q;

    // Hold the edge select bit (0 falling, 1 rising).
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rise_sel_q <= 1'b0;
        end else if (cfg_we_i) begin
            rise_sel_q <= cfg_wdata_i;
        end
    end

    // Recognize the selected edge.
    always_comb begin
        hit = rise_sel_q ? (!prev_i && cur_i) : (prev_i && !cur_i);
    end

    // Latched flag; an edge outranks a clear.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign req_o = flag_q;
endmodule

// File: rtl/extirq_ctrl.sv
// External interrupt request controller top.
// Synchronizes all pins, merges keyed and wake inputs (active low) onto the
// two shared lines, runs one channel per general line and the non-maskable
// channel, and forms the standby wake-up output from the permitted sources.
// Assumes N_IRQ >= 8 so that lines 7 and 6 exist.
module extirq_ctrl #(
    parameter int          N_IRQ     = 8,
    parameter int          N_KEY     = 16,
    parameter int          N_WAKE    = 8,
    parameter int          LINE_HI   = 7,
    parameter int          LINE_LO   = 6,
    parameter logic [7:0]  WAKE_MASK = 8'hC7
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [N_IRQ-1:0]   irq_pin_i,
    input  logic [N_KEY-1:0]   key_i,
    input  logic [N_WAKE-1:0]  wake_i,
    input  logic               nmi_pin_i,
    input  logic               sense_we_i,
    input  logic [2*N_IRQ-1:0] sense_wdata_i,
    input  logic               en_we_i,
    input  logic [N_IRQ-1:0]   en_wdata_i,
    input  logic [N_IRQ-1:0]   flag_clr_i,
    input  logic               nmi_cfg_we_i,
    input  logic               nmi_cfg_wdata_i,
    input  logic               nmi_clr_i,
    output logic [N_IRQ-1:0]   irq_flag_o,
    output logic [N_IRQ-1:0]   irq_req_o,
    output logic               nmi_req_o,
    output logic               stby_wake_o
);
    localparam int SW      = N_IRQ + N_KEY + N_WAKE + 1;
    localparam int KEY_LSB = N_IRQ;
    localparam int WK_LSB  = N_IRQ + N_KEY;
    localparam int NMI_BIT = SW - 1;
    localparam int KEY_MID = N_KEY / 2;

    logic [SW-1:0]      s_cur;
    logic [SW-1:0]      s_prev;
    logic [N_IRQ-1:0]   line_cur;
    logic [N_IRQ-1:0]   line_prev;
    logic [2*N_IRQ-1:0] sense_q;
    logic [N_IRQ-1:0]   en_q;
    logic [N_IRQ-1:0]   chan_set;

    extirq_sync #(.W(SW), .RST_VAL(1'b1)) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i({nmi_pin_i, wake_i, key_i, irq_pin_i}),
        .cur_o  (s_cur),
        .prev_o (s_prev)
    );

    // Merge the active-low shared inputs into the line samples (wired AND).
    always_comb begin
        line_cur  = s_cur[N_IRQ-1:0];
        line_prev = s_prev[N_IRQ-1:0];
        line_cur[LINE_HI]  = s_cur[LINE_HI] & (&s_cur[KEY_LSB+KEY_MID +: N_KEY-KEY_MID])
                           & (&s_cur[WK_LSB +: N_WAKE]);
        line_prev[LINE_HI] = s_prev[LINE_HI] & (&s_prev[KEY_LSB+KEY_MID +: N_KEY-KEY_MID])
                           & (&s_prev[WK_LSB +: N_WAKE]);
        line_cur[LINE_LO]  = s_cur[LINE_LO] & (&s_cur[KEY_LSB +: KEY_MID]);
        line_prev[LINE_LO] = s_prev[LINE_LO] & (&s_prev[KEY_LSB +: KEY_MID]);
    end

    // Sense and enable registers, written whole through their strobes.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sense_q <= '0;
            en_q    <= '0;
        end else begin
            if (sense_we_i) sense_q <= sense_wdata_i;
            if (en_we_i)    en_q    <= en_wdata_i;
        end
    end

    for (genvar n = 0; n < N_IRQ; n++) begin : g_chan
        extirq_chan chan_i (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .cur_i  (line_cur[n]),
            .prev_i (line_prev[n]),
            .sense_i(sense_q[2*n +: 2]),
            .clr_i  (flag_clr_i[n]),
            .en_i   (en_q[n]),
            .set_o  (chan_set[n]),
            .flag_o (irq_flag_o[n]),
            .req_o  (irq_req_o[n])
        );
    end

    extirq_nmi nmi_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cur_i      (s_cur[NMI_BIT]),
        .prev_i     (s_prev[NMI_BIT]),
        .cfg_we_i   (nmi_cfg_we_i),
        .cfg_wdata_i(nmi_cfg_wdata_i),
        .clr_i      (nmi_clr_i),
        .req_o      (nmi_req_o)
    );

    // Standby wake-up from the non-maskable flag or a permitted request line.
    always_comb begin
        stby_wake_o = nmi_req_o | (|(irq_req_o[7:0] & WAKE_MASK));
    end
endmodule

// File: rtl/extirq_ctrl_chk.sv
// Assertion checker for extirq_ctrl, attached by bind below.
module extirq_ctrl_chk #(
    parameter int N = 8
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic [N-1:0] flag_clr_i,
    input logic [N-1:0] set_ev,
    input logic [N-1:0] irq_flag_o,
    input logic [N-1:0] irq_req_o,
    input logic         nmi_req_o,
    input logic         nmi_clr_i,
    input logic         stby_wake_o
);
    // R3: a request is never out without its flag.
    a_r3_req_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_req_o & ~irq_flag_o) == '0);

    // R8: wake only from the non-maskable flag or a permitted request.
    a_r8_wake_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stby_wake_o |-> (nmi_req_o || (irq_req_o[7:6] != 2'b00) || (irq_req_o[2:0] != 3'b000)));

    // R8: requests 5..3 alone never wake.
    a_r8_mid_lines_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!nmi_req_o && irq_req_o[7:6] == 2'b00 && irq_req_o[2:0] == 3'b000) |-> !stby_wake_o);

    // R6: the non-maskable flag holds until cleared.
    a_r6_nmi_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (nmi_req_o && !nmi_clr_i) |=> nmi_req_o);

    for (genvar n = 0; n < N; n++) begin : g_line
        // R4: a clear without a set event empties the flag.
        a_r4_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (flag_clr_i[n] && !set_ev[n]) |=> !irq_flag_o[n]);
        // R5: a set event wins over a simultaneous clear.
        a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_ev[n] |=> irq_flag_o[n]);
        // R4: without a clear, a flag never drops.
        a_r4_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (irq_flag_o[n] && !flag_clr_i[n]) |=> irq_flag_o[n]);
    end
endmodule

bind extirq_ctrl extirq_ctrl_chk #(.N(N_IRQ)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flag_clr_i (flag_clr_i),
    .set_ev     (chan_set),
    .irq_flag_o (irq_flag_o),
    .irq_req_o  (irq_req_o),
    .nmi_req_o  (nmi_req_o),
    .nmi_clr_i  (nmi_clr_i),
    .stby_wake_o(stby_wake_o)
);

// File: tb/extirq_ctrl_tb_top.sv
// Directed bench for extirq_ctrl: one task per scenario.
module extirq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  pin;
    logic [15:0] key;
    logic [7:0]  wk;
    logic        nmi;
    logic        sense_we;
    logic [15:0] sense_wd;
    logic        en_we;
    logic [7:0]  en_wd;
    logic [7:0]  clr;
    logic        ncfg_we;
    logic        ncfg_wd;
    logic        nclr;
    logic [7:0]  flag;
    logic [7:0]  req;
    logic        nreq;
    logic        wake;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    extirq_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .irq_pin_i(pin), .key_i(key), .wake_i(wk),
        .nmi_pin_i(nmi), .sense_we_i(sense_we), .sense_wdata_i(sense_wd),
        .en_we_i(en_we), .en_wdata_i(en_wd), .flag_clr_i(clr),
        .nmi_cfg_we_i(ncfg_we), .nmi_cfg_wdata_i(ncfg_wd), .nmi_clr_i(nclr),
        .irq_flag_o(flag), .irq_req_o(req), .nmi_req_o(nreq), .stby_wake_o(wake)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_sense(input logic [15:0] v);
        sense_we = 1'b1; sense_wd = v; tick(1); sense_we = 1'b0;
    endtask

    task automatic wr_en(input logic [7:0] v);
        en_we = 1'b1; en_wd = v; tick(1); en_we = 1'b0;
    endtask

    task automatic do_clr(input logic [7:0] m);
        clr = m; tick(1); clr = 8'h00;
    endtask

    task automatic t_reset;
        check("R9 flags after reset", flag, 8'h00);
        check("R9 req after reset", req, 8'h00);
        check("R9 nmi after reset", nreq, 1'b0);
        check("R9 wake after reset", wake, 1'b0);
        pin[0] = 1'b0; tick(3);
        check("R9 default sense is low level", flag[0], 1'b1);
        check("R9 default enable off", req[0], 1'b0);
        pin[0] = 1'b1; tick(2); do_clr(8'hFF);
        check("R9 flag cleared after pin high", flag, 8'h00);
    endtask

    task automatic t_falling;
        pin[0] = 1'b0; tick(2);
        check("R1 no flag after two edges", flag[0], 1'b0);
        tick(1);
        check("R1 R2 falling sets on third edge", flag[0], 1'b1);
        check("R3 req with enable", req[0], 1'b1);
        do_clr(8'h01);
        check("R4 clear in edge mode", flag[0], 1'b0);
        pin[0] = 1'b1; tick(3);
        check("R2 falling mode ignores rise", flag[0], 1'b0);
    endtask

    task automatic t_rising;
        pin[1] = 1'b0; tick(3);
        check("R2 rising mode ignores fall", flag[1], 1'b0);
        pin[1] = 1'b1; tick(3);
        check("R2 rising sets", flag[1], 1'b1);
        do_clr(8'h02);
    endtask

    task automatic t_both;
        pin[2] = 1'b0; tick(3);
        check("R2 both mode on fall", flag[2], 1'b1);
        do_clr(8'h04);
        check("R4 clear both mode", flag[2], 1'b0);
        pin[2] = 1'b1; tick(3);
        check("R2 both mode on rise", flag[2], 1'b1);
        do_clr(8'h04);
    endtask

    task automatic t_low;
        pin[4] = 1'b0; tick(3);
        check("R2 low level sets", flag[4], 1'b1);
        do_clr(8'h10);
        check("R4 clear ignored while low", flag[4], 1'b1);
        pin[4] = 1'b1; tick(2);
        do_clr(8'h10);
        check("R4 clear after pin high", flag[4], 1'b0);
    endtask

    task automatic t_enable;
        wr_en(8'hDF);
        pin[5] = 1'b0; tick(3);
        check("R3 flag set while disabled", flag[5], 1'b1);
        check("R3 req masked", req[5], 1'b0);
        wr_en(8'hFF);
        check("R3 req after enable write", req[5], 1'b1);
        pin[5] = 1'b1; do_clr(8'h20); tick(3);
    endtask

    task automatic t_set_wins;
        pin[3] = 1'b0; tick(2);
        clr[3] = 1'b1; tick(1); clr[3] = 1'b0;
        check("R5 set beats clear", flag[3], 1'b1);
        do_clr(8'h08);
        check("R5 later clear works", flag[3], 1'b0);
        pin[3] = 1'b1; tick(3);
    endtask

    task automatic t_shared;
        key[12] = 1'b0; tick(3);
        check("R7 high keyed sets line 7", flag, 8'h80);
        check("R8 line 7 wakes", wake, 1'b1);
        key[12] = 1'b1; tick(3); do_clr(8'h80);
        wk[3] = 1'b0; tick(3);
        check("R7 wake input sets line 7", flag, 8'h80);
        wk[3] = 1'b1; tick(3); do_clr(8'h80);
        key[2] = 1'b0; tick(3);
        check("R7 low keyed sets line 6", flag, 8'h40);
        key[2] = 1'b1; tick(3); do_clr(8'h40);
        check("R7 flags idle", flag, 8'h00);
    endtask

    task automatic t_wake;
        pin[3] = 1'b0; pin[5] = 1'b0; tick(3);
        check("R8 req 3 and 5 set", req, 8'h28);
        check("R8 lines 3 and 5 do not wake", wake, 1'b0);
        pin[3] = 1'b1; pin[5] = 1'b1; tick(3); do_clr(8'h28);
        pin[2] = 1'b0; tick(3);
        check("R8 line 2 wakes", wake, 1'b1);
        pin[2] = 1'b1; tick(3); do_clr(8'h04);
        check("R8 wake drops after clear", wake, 1'b0);
    endtask

    task automatic t_nmi;
        nmi = 1'b0; tick(2);
        check("R1 nmi not before third edge", nreq, 1'b0);
        tick(1);
        check("R6 nmi falling default", nreq, 1'b1);
        check("R8 nmi wakes", wake, 1'b1);
        nclr = 1'b1; tick(1); nclr = 1'b0;
        check("R6 nmi clear", nreq, 1'b0);
        nmi = 1'b1; tick(3);
        check("R6 rise ignored in falling mode", nreq, 1'b0);
        ncfg_we = 1'b1; ncfg_wd = 1'b1; tick(1); ncfg_we = 1'b0;
        nmi = 1'b0; tick(3);
        check("R6 fall ignored in rising mode", nreq, 1'b0);
        nmi = 1'b1; tick(3);
        check("R6 rising mode sets", nreq, 1'b1);
        nclr = 1'b1; tick(1); nclr = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; pin = 8'hFF; key = 16'hFFFF; wk = 8'hFF; nmi = 1'b1;
        sense_we = 1'b0; sense_wd = '0; en_we = 1'b0; en_wd = '0; clr = '0;
        ncfg_we = 1'b0; ncfg_wd = 1'b0; nclr = 1'b0;
        tick(3);
        rst_n = 1'b1; tick(1);
        t_reset();
        wr_sense(16'h5479);
        wr_en(8'hFF);
        t_falling();
        t_rising();
        t_both();
        t_low();
        t_enable();
        t_set_wins();
        t_shared();
        t_wake();
        t_nmi();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule